// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block is the control-flow part of a small byte-oriented processor core. It owns the program counter and the stack pointer, both 16 bits wide. It carries out jumps, subroutine calls and returns, pushes and pops of 16-bit register pairs, and loads of the program counter from a register pair. Jumps, calls and returns can be made conditional on one of eight flag tests. A shared 3-bit condition code selects the test.

Instruction decode drives the block through a one-cycle command strobe. The strobe carries the operation, the condition code, the current flags, a 16-bit target, a 16-bit register-pair value and the address of the next instruction. The sequencer reaches a byte-wide memory with asynchronous read and moves one byte per cycle. On completion it raises `done` for a single cycle, and `popPair` holds any value taken off the stack. When the processor-status pair is pushed, the caller supplies it as {accumulator, flags}, so the accumulator lands at the higher address. A pop of that pair returns it in the same layout.

Top module: `callret_seq`

## Requirements
- R1: After reset, `pc` is 0, `sp` equals parameter SP_INIT (default 0), and `done`, `busy` and `memWe` are all 0.
- R2: Condition codes: 0 = Z clear, 1 = Z set, 2 = CY clear, 3 = CY set, 4 = P clear, 5 = P set, 6 = S clear, 7 = S set. Flag bit positions are `flags[0]` = Z, `flags[1]` = CY, `flags[2]` = P, `flags[3]` = S. With `cmdUseCond` = 0 the command is always taken.
- R3: Operation codes are 0 = jump, 1 = call, 2 = return, 3 = push, 4 = pop and 5 = pc-from-pair. A taken jump loads `pc` with `cmdTarget`, makes no memory write, and raises `done` in the cycle after acceptance.
- R4: A taken call writes the high byte of `cmdNext` to address sp-1 in the first cycle after acceptance. It writes the low byte to sp-2 in the second cycle. It then sets sp to sp-2 and pc to `cmdTarget`, with `done` in the third cycle.
- R5: A taken return reads address sp in the first cycle and address sp+1 in the second. It sets pc to {byte at sp+1, byte at sp} and sp to sp+2, with `done` in the third cycle.
- R6: A push writes the high byte of `cmdPair` to sp-1, then the low byte to sp-2, with no condition. It then sets sp to sp-2 and leaves pc unchanged, with `done` in the third cycle.
- R7: A pop reads sp and then sp+1, presents {byte at sp+1, byte at sp} on `popPair` while `done` is high, and sets sp to sp+2. It leaves pc unchanged.
- R8: A pc-from-pair command loads `pc` with `cmdPair`, leaves sp unchanged, makes no memory write, and raises `done` in the next cycle.
- R9: A conditional jump, call or return whose condition is false loads `pc` with `cmdNext`. It leaves sp unchanged, makes no memory write, and raises `done` in the next cycle.
- R10: All stack-pointer arithmetic and stack addresses wrap modulo 2^16.
- R11: `done` is high for exactly one cycle per command. `busy` is high from acceptance until `done` has fallen. A `cmdValid` asserted while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 3 | Operation code |
| cmdCond | input | 3 | Condition code |
| cmdUseCond | input | 1 | 1 = conditional form |
| flags | input | 4 | {S, P, CY, Z} |
| cmdTarget | input | 16 | Jump or call target |
| cmdPair | input | 16 | Register-pair value |
| cmdNext | input | 16 | Address of the next instruction |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data (asynchronous) |
| memWe | output | 1 | Memory write enable |
| done | output | 1 | One-cycle completion pulse |
| popPair | output | 16 | Last value popped from the stack |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Command in progress |

## Verification
Commands that do not touch the stack finish one cycle after the accepting edge. That covers jumps, pc-from-pair and any untaken condition. Commands that move two stack bytes finish three cycles after it. The bench counts falling edges from acceptance to `done` and compares the count with the latency it expects for the command. It checks `memAddr`, `memWe` and `memWdata` at the first and second falling edges, where each stack byte is due. It reads `pc`, `sp` and `popPair` on the falling edge where `done` is high, and checks one edge later that `done` has dropped.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_JMP    = 3'd0,
    OP_CALL   = 3'd1,
    OP_RET    = 3'd2,
    OP_PUSH   = 3'd3,
    OP_POP    = 3'd4,
    OP_PCPAIR = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    PC_KEEP, PC_TGT, PC_LTGT, PC_NEXT, PC_PAIR, PC_STACK
  } pc_src_e;

  typedef enum logic [1:0] {
    A_SPM1, A_SPM2, A_SP, A_SPP1
  } addr_sel_e;

  typedef struct packed {
    pc_src_e   pcSrc;
    addr_sel_e addrSel;
    logic      latch;
    logic      latchNext;
    logic      wrHi;
    logic      we;
    logic      capLo;
    logic      spDec2;
    logic      spInc2;
  } strobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [2:0] cmdCond,
  input  logic       cmdUseCond,
  input  logic [3:0] flags,
  output strobe_t    strb,
  output logic       done,
  output logic       busy
);
  typedef enum logic [2:0] {S_IDLE, S_WHI, S_WLO, S_RLO, S_RHI, S_FIN} state_e;

  state_e state, stateNxt;
  op_e    opQ;
  logic   condHit, taken, accept;

  assign condHit = (flags[cmdCond[2:1]] == cmdCond[0]);
  assign taken   = !cmdUseCond || condHit;
  assign accept  = (state == S_IDLE) && cmdValid;

  always_comb begin
    strb     = '0;
    strb.pcSrc   = PC_KEEP;
    strb.addrSel = A_SP;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        stateNxt = S_FIN;
        unique case (cmdOp)
          OP_JMP:    strb.pcSrc = taken ? PC_TGT : PC_NEXT;
          OP_PCPAIR: strb.pcSrc = PC_PAIR;
          OP_CALL:   if (taken) begin
                       strb.latch = 1'b1; strb.latchNext = 1'b1; stateNxt = S_WHI;
                     end else strb.pcSrc = PC_NEXT;
          OP_PUSH:   begin strb.latch = 1'b1; stateNxt = S_WHI; end
          OP_RET:    if (taken) stateNxt = S_RLO;
                     else strb.pcSrc = PC_NEXT;
          OP_POP:    stateNxt = S_RLO;
          default:   ;
        endcase
      end
      S_WHI: begin
        strb.addrSel = A_SPM1; strb.we = 1'b1; strb.wrHi = 1'b1; stateNxt = S_WLO;
      end
      S_WLO: begin
        strb.addrSel = A_SPM2; strb.we = 1'b1; strb.spDec2 = 1'b1;
        strb.pcSrc   = (opQ == OP_CALL) ? PC_LTGT : PC_KEEP;
        stateNxt     = S_FIN;
      end
      S_RLO: begin
        strb.addrSel = A_SP; strb.capLo = 1'b1; stateNxt = S_RHI;
      end
      S_RHI: begin
        strb.addrSel = A_SPP1; strb.spInc2 = 1'b1;
        strb.pcSrc   = (opQ == OP_RET) ? PC_STACK : PC_KEEP;
        stateNxt     = S_FIN;
      end
      S_FIN:   stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_JMP;
    end else begin
      state <= stateNxt;
      if (accept) opQ <= op_e'(cmdOp);
    end
  end

  assign done = (state == S_FIN);
  assign busy = (state != S_IDLE);

  // R11: completion pulse never lasts two cycles
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R11: busy covers the done cycle
  a_r11_busy_done: assert property (@(posedge clk) disable iff (!rstN) done |-> busy);
  // R4 / R6: high-byte write is always followed by the low-byte write
  a_r4_write_pair: assert property (@(posedge clk) disable iff (!rstN)
    (strb.we && strb.wrHi) |=> (strb.we && !strb.wrHi));
  // R9: an idle-cycle decision never writes memory in the following cycle unless a stack write was chosen
  a_r9_short_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !strb.latch) |=> !strb.we);
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cmdTarget,
  input  logic [ADDR_W-1:0] cmdPair,
  input  logic [ADDR_W-1:0] cmdNext,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] popPair,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] pcQ, spQ, tgtQ, datQ, pcNxt;
  logic [BYTE_W-1:0] loQ, hiQ;

  always_comb begin
    unique case (strb.addrSel)
      A_SPM1:  memAddr = spQ - ONE;
      A_SPM2:  memAddr = spQ - TWO;
      A_SP:    memAddr = spQ;
      default: memAddr = spQ + ONE;
    endcase
  end

  assign memWdata = strb.wrHi ? datQ[ADDR_W-1:BYTE_W] : datQ[BYTE_W-1:0];
  assign memWe    = strb.we;

  always_comb begin
    unique case (strb.pcSrc)
      PC_TGT:   pcNxt = cmdTarget;
      PC_LTGT:  pcNxt = tgtQ;
      PC_NEXT:  pcNxt = cmdNext;
      PC_PAIR:  pcNxt = cmdPair;
      PC_STACK: pcNxt = {memRdata, loQ};
      default:  pcNxt = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      spQ  <= SP_INIT;
      tgtQ <= '0;
      datQ <= '0;
      loQ  <= '0;
      hiQ  <= '0;
    end else begin
      pcQ <= pcNxt;
      if (strb.latch) begin
        tgtQ <= cmdTarget;
        datQ <= strb.latchNext ? cmdNext : cmdPair;
      end
      if (strb.capLo) loQ <= memRdata;
      if (strb.spInc2) begin
        hiQ <= memRdata;
        spQ <= spQ + TWO;
      end else if (strb.spDec2) begin
        spQ <= spQ - TWO;
      end
    end
  end

  assign pc      = pcQ;
  assign sp      = spQ;
  assign popPair = {hiQ, loQ};

  // R10: a push-type completion lowers sp by two, wrapping
  a_r10_sp_dec: assert property (@(posedge clk) disable iff (!rstN)
    strb.spDec2 |=> (spQ == $past(spQ) - TWO));
  // R10: a pop-type completion raises sp by two, wrapping
  a_r10_sp_inc: assert property (@(posedge clk) disable iff (!rstN)
    strb.spInc2 |=> (spQ == $past(spQ) + TWO));
  // R6: pc holds when no source is selected
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pcSrc == PC_KEEP) |=> $stable(pcQ));
  // R5: a return loads pc from the two bytes it read
  a_r5_ret_pc: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pcSrc == PC_STACK) |=> (pcQ == popPair));
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import seq_pkg::*;
#(
  parameter logic [15:0] SP_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [2:0]  cmdCond,
  input  logic        cmdUseCond,
  input  logic [3:0]  flags,
  input  logic [15:0] cmdTarget,
  input  logic [15:0] cmdPair,
  input  logic [15:0] cmdNext,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        memWe,
  output logic        done,
  output logic [15:0] popPair,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic        busy
);
  strobe_t strb;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCond(cmdCond), .cmdUseCond(cmdUseCond), .flags(flags),
    .strb(strb), .done(done), .busy(busy)
  );

  seq_dpath #(.SP_INIT(SP_INIT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdTarget(cmdTarget),
    .cmdPair(cmdPair), .cmdNext(cmdNext), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .popPair(popPair), .pc(pc), .sp(sp)
  );
endmodule

// File: tb/callret_seq_tb.sv
module callret_seq_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0, cmdCond = '0;
  logic        cmdUseCond = 1'b0;
  logic [3:0]  flags = '0;
  logic [15:0] cmdTarget = '0, cmdPair = '0, cmdNext = '0;
  logic [15:0] memAddr, popPair, pc, sp;
  logic [7:0]  memWdata, memRdata;
  logic        memWe, done, busy;

  logic [7:0]  mem [256];
  logic [7:0]  mdl [256];
  logic [15:0] expPc, expSp;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callret_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdCond(cmdCond),
    .cmdUseCond(cmdUseCond), .flags(flags), .cmdTarget(cmdTarget), .cmdPair(cmdPair),
    .cmdNext(cmdNext), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memWe(memWe), .done(done), .popPair(popPair), .pc(pc), .sp(sp), .busy(busy)
  );

  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memWe) mem[memAddr[7:0]] <= memWdata;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R2: flag test from the condition-code table
  function automatic bit condOk(input logic [2:0] c, input logic [3:0] f);
    case (c)
      3'd0: return !f[0];
      3'd1: return  f[0];
      3'd2: return !f[1];
      3'd3: return  f[1];
      3'd4: return !f[2];
      3'd5: return  f[2];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  task automatic runCmd(input logic [2:0] op, input logic [2:0] cnd, input logic uc,
                        input logic [3:0] fl, input logic [15:0] tgt, input logic [15:0] pair,
                        input logic [15:0] nxt, input string tag, input bit poke);
    bit tk, wr, rd;
    int lat, n;
    logic [15:0] a1, a2, expPop, dv;
    logic [7:0] lo, hi;
    tk = !uc || condOk(cnd, fl);
    wr = 0; rd = 0; lat = 1; expPop = 16'h0; dv = 16'h0; a1 = 16'h0; a2 = 16'h0;
    case (op)
      3'd0: expPc = tk ? tgt : nxt;
      3'd5: expPc = pair;
      3'd1, 3'd3: if (op == 3'd3 || tk) begin
        dv = (op == 3'd1) ? nxt : pair;
        wr = 1; lat = 3; a1 = expSp - 16'd1; a2 = expSp - 16'd2;
        mdl[a1[7:0]] = dv[15:8]; mdl[a2[7:0]] = dv[7:0];
        expSp = expSp - 16'd2;
        if (op == 3'd1) expPc = tgt;
      end else expPc = nxt;
      3'd2, 3'd4: if (op == 3'd4 || tk) begin
        rd = 1; lat = 3; a1 = expSp; a2 = expSp + 16'd1;
        lo = mdl[a1[7:0]]; hi = mdl[a2[7:0]];
        expPop = {hi, lo};
        expSp = expSp + 16'd2;
        if (op == 3'd2) expPc = {hi, lo};
      end else expPc = nxt;
      default: ;
    endcase
    cmdOp = op; cmdCond = cnd; cmdUseCond = uc; flags = fl;
    cmdTarget = tgt; cmdPair = pair; cmdNext = nxt; cmdValid = 1'b1;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      cmdValid = 1'b0;
      if (n == 1 && (wr || rd)) begin
        check(memAddr == a1, {tag, " first stack address"}, memAddr, a1);
        check(memWe == wr, {tag, " first write enable"}, memWe, wr);
        if (wr) check(memWdata == dv[15:8], {tag, " high byte"}, memWdata, dv[15:8]);
        if (poke) begin // R11: command while busy must be ignored
          cmdOp = 3'd0; cmdUseCond = 1'b0; cmdTarget = 16'hDEAD; cmdValid = 1'b1;
        end
      end
      if (n == 2 && (wr || rd)) begin
        check(memAddr == a2, {tag, " second stack address"}, memAddr, a2);
        check(memWe == wr, {tag, " second write enable"}, memWe, wr);
        if (wr) check(memWdata == dv[7:0], {tag, " low byte"}, memWdata, dv[7:0]);
      end
      if (n == 1 && !(wr || rd)) check(memWe == 1'b0, {tag, " no write"}, memWe, 0);
      if (done || n > 8) break;
    end
    check(n == lat, {tag, " latency"}, n, lat);
    check(pc == expPc, {tag, " pc"}, pc, expPc);
    check(sp == expSp, {tag, " sp"}, sp, expSp);
    if (rd) check(popPair == expPop, {tag, " popPair"}, popPair, expPop);
    @(negedge clk);
    cmdValid = 1'b0;
    check(!done && !busy, {tag, " R11 done single cycle"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; mdl[i] = 8'h00; end
    expPc = 16'h0; expSp = 16'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pc == 16'h0, "R1 pc after reset", pc, 0);
    check(sp == 16'h0, "R1 sp after reset", sp, 0);
    check(!done && !busy && !memWe, "R1 idle outputs", {done, busy, memWe}, 0);

    runCmd(3'd3, 3'd0, 1'b0, 4'h0, 16'h0, 16'h1234, 16'h0, "R6 R10 push wraps", 0);
    runCmd(3'd3, 3'd0, 1'b0, 4'h0, 16'h0, 16'hA50F, 16'h0, "R6 push status pair", 0);
    runCmd(3'd4, 3'd0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, "R7 pop status pair", 0);
    runCmd(3'd1, 3'd0, 1'b0, 4'h0, 16'h4000, 16'h0, 16'h0103, "R4 R11 call with poke", 1);
    runCmd(3'd2, 3'd1, 1'b1, 4'h1, 16'h0, 16'h0, 16'h4001, "R5 R2 return on zero", 0);
    runCmd(3'd2, 3'd3, 1'b1, 4'h0, 16'h0, 16'h0, 16'h0777, "R9 return not taken", 0);
    runCmd(3'd1, 3'd6, 1'b1, 4'h8, 16'h5000, 16'h0, 16'h0800, "R9 call not taken", 0);
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f += 15)
        runCmd(3'd0, 3'(c), 1'b1, 4'(f), 16'h2000 + 16'(c), 16'h0, 16'h3000 + 16'(c),
               "R2 R3 R9 conditional jump", 0);
    runCmd(3'd5, 3'd0, 1'b0, 4'h0, 16'h0, 16'hBEEF, 16'h0, "R8 pc from pair", 0);
    runCmd(3'd4, 3'd0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, "R7 R10 pop back to zero", 0);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      runCmd(3'(r[2:0] % 6), r[5:3], r[6], r[10:7], 16'($urandom), 16'($urandom),
             16'($urandom), "R3 R4 R5 R6 R7 R8 R9 random", r[11]);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule